// File: doc/BRIEF.md
# Unlock-Sequence Flash Command Decoder

This block is the command front end of a byte-wide parallel flash. Each bus write reaches it as a one-cycle strobe with the address and data byte already captured. The decoder checks the writes against guarded multi-cycle sequences. Every command except the simplest needs a two-write unlock prefix. The decoder then sends single-cycle requests to the program/erase engine: start a program, start a chip erase, start a block erase, suspend, resume, or abort. It also tracks which mode the part is in and tells the read multiplexer where a bus read takes its byte from. The source can be the array, an identification byte that the decoder supplies, or the status word that the engine produces.

A fast-program mode cuts each program to two writes. A block erase first opens a selection window, and during that window further blocks can be added to the list. A block erase can be suspended and resumed. While it is suspended, blocks that are not being erased can be read and programmed. The engine reports completion through `eng_done`, and an error through `eng_err` in the same cycle. After an error the decoder keeps the status word selected until a reset command arrives.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset `mode` is 0 (read), `rd_src` is 0 (array), and all request pulses are low. The `mode` codes are: 0 read, 1 identify, 2 fast-program, 3 suspended, 4 erase window, 5 programming, 6 chip erasing, 7 block erasing, 8 error. The `rd_src` codes are: 0 array, 1 identify byte, 2 status.
- R2: The unlock prefix is data AAh at address 555h followed by data 55h at address 2AAh. Only `wr_addr[10:0]` is compared. A third write of 90h at 555h puts the decoder in identify mode.
- R3: In identify mode `rd_src` is 1 and `rd_id` is selected by `rd_addr[1:0]`. The values are 20h for 00, E3h for 01, and 00h for 11. For 10 the value is 01h when the block named by `rd_addr[18:16]` is protected in `prot_mask`, and 00h when it is not.
- R4: Prefix, A0h at 555h, then a fourth write carrying the target address and byte. In the cycle after the fourth write, `start_prog` pulses for one cycle with that address and byte. Mode then becomes 5 and `rd_src` becomes 2. All writes are ignored until `eng_done`, which returns the decoder to the mode it came from.
- R5: A program whose target block is protected is dropped. No request is issued and the decoder returns to its resting mode.
- R6: A write that breaks a sequence sends the decoder to its resting mode and clears any partial sequence. The resting mode is read mode, or suspended mode while an erase is suspended.
- R7: A write of F0h returns the decoder to its resting mode. This holds at any address and at any step of a sequence, except the step that carries a program's data byte.
- R8: Prefix followed by 20h at 555h enters fast-program mode (2), where reads select the array. In this mode, A0h followed by an address/byte write programs. 90h followed by 00h returns to read mode. Every other write is ignored. When the engine finishes a program, the decoder returns to fast-program mode.
- R9: Prefix, 80h, prefix, then 10h at 555h pulses `start_chip` and enters mode 6. Every write is ignored until `eng_done`.
- R10: Prefix, 80h, prefix, then 30h at any address opens the erase window (mode 4) and sets the bit in `erase_blks` for block `wr_addr[18:16]`. Each further 30h write adds its block and restarts the window. `start_blk` pulses WIN_CYC cycles after the last 30h write, and mode then becomes 7.
- R11: In mode 7, B0h pulses `susp_req` and enters mode 3. In mode 3, reads from listed blocks select the status and other reads select the array. 30h pulses `resume_req` and returns to mode 7. F0h in mode 7 pulses `abort_req`, clears the list and returns to read mode.
- R12: B0h written during the erase window suspends without `susp_req`. A following 30h pulses `start_blk` rather than `resume_req`.
- R13: While suspended, a program aimed at an unlisted block starts and then returns to mode 3. A program aimed at a listed block is dropped.
- R14: `eng_done` with `eng_err` set enters mode 8, where `rd_src` is 2. Only an F0h write leaves mode 8, and it returns to the resting mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_stb | input | 1 | One-cycle bus write strobe |
| wr_addr | input | 19 | Captured write address |
| wr_data | input | 8 | Captured write byte |
| rd_addr | input | 19 | Current read address |
| prot_mask | input | 8 | Per-block protection flags |
| eng_done | input | 1 | Engine finished its operation |
| eng_err | input | 1 | Engine operation failed, valid with eng_done |
| mode | output | 4 | Decoder mode code |
| rd_src | output | 2 | Read source select |
| rd_id | output | 8 | Identify byte for the current read address |
| start_prog | output | 1 | Program request pulse |
| start_chip | output | 1 | Chip erase request pulse |
| start_blk | output | 1 | Block erase request pulse |
| susp_req | output | 1 | Erase suspend request pulse |
| resume_req | output | 1 | Erase resume request pulse |
| abort_req | output | 1 | Erase abort request pulse |
| prog_addr | output | 19 | Program target address |
| prog_data | output | 8 | Program byte |
| erase_blks | output | 8 | Blocks listed for block erase |

## Verification
The assertions assume that `prot_mask` changes only between operations. They also assume that `eng_done` arrives only while an operation is running, and that it never coincides with the erase window expiring. The bench satisfies these by setting the protection flags before each scenario. It raises `eng_done` only by hand, after a start request has been observed. It leaves the window timer alone until the expiry check has been made.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int CMD_AW = 11;
  localparam logic [CMD_AW-1:0] ADR_KEY1 = 11'h555;
  localparam logic [CMD_AW-1:0] ADR_KEY2 = 11'h2AA;

  localparam logic [7:0] D_KEY1 = 8'hAA;
  localparam logic [7:0] D_KEY2 = 8'h55;
  localparam logic [7:0] D_IDENT = 8'h90;
  localparam logic [7:0] D_PROG = 8'hA0;
  localparam logic [7:0] D_FAST = 8'h20;
  localparam logic [7:0] D_ERASE = 8'h80;
  localparam logic [7:0] D_CHIP = 8'h10;
  localparam logic [7:0] D_BLOCK = 8'h30;
  localparam logic [7:0] D_RESET = 8'hF0;
  localparam logic [7:0] D_SUSP = 8'hB0;
  localparam logic [7:0] D_FEXIT = 8'h00;

  typedef enum logic [3:0] {
    M_READ = 4'd0, M_IDENT = 4'd1, M_FAST = 4'd2, M_SUSP = 4'd3, M_WIN = 4'd4,
    M_PROG = 4'd5, M_CHIP = 4'd6, M_BERASE = 4'd7, M_ERR = 4'd8
  } mode_t;

  typedef enum logic [1:0] {SRC_ARRAY = 2'd0, SRC_IDENT = 2'd1, SRC_STATUS = 2'd2} src_t;

  typedef enum logic [3:0] {
    C_IDLE, C_K1, C_K2, C_PDATA, C_E1, C_E2, C_E3, C_FPDATA, C_FEXIT
  } step_t;

  function automatic logic cmd_hit(logic [CMD_AW-1:0] a, logic [7:0] d,
                                   logic [CMD_AW-1:0] ea, logic [7:0] ed);
    return (a == ea) && (d == ed);
  endfunction

  function automatic logic [7:0] ident_byte(logic [1:0] sel, logic prot,
                                            logic [7:0] mfr, logic [7:0] dev);
    case (sel)
      2'b00: return mfr;
      2'b01: return dev;
      2'b10: return {7'd0, prot};
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/fcd_win_timer.sv
module fcd_win_timer #(
  parameter int WIN_CYC = 64,
  localparam int CW = $clog2(WIN_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic win_wr,
  output logic expire
);
  logic [CW-1:0] cnt_q;
  localparam logic [CW-1:0] LIM = CW'(WIN_CYC - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (!run || win_wr) cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign expire = run && !win_wr && (cnt_q == LIM);
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq import fcd_pkg::*; #(
  parameter int ADDR_W = 19,
  parameter int BLK_W = 3,
  localparam int NBLK = 1 << BLK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [NBLK-1:0]   prot_mask,
  input  logic              eng_done,
  input  logic              eng_err,
  input  logic              win_expire,
  output mode_t             mode,
  output logic              win_wr,
  output logic              start_prog,
  output logic              start_chip,
  output logic              start_blk,
  output logic              susp_req,
  output logic              resume_req,
  output logic              abort_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_data,
  output logic [NBLK-1:0]   erase_blks
);
  mode_t mode_q, mode_n, home_q, home_n;
  step_t step_q, step_n;
  logic started_q, started_n;
  logic [NBLK-1:0] blk_q, blk_n, wr_onehot;
  logic [ADDR_W-1:0] paddr_q, paddr_n;
  logic [7:0] pdata_q, pdata_n;
  logic [5:0] pulse_q, pulse_n;  // prog, chip, blk, susp, resume, abort
  logic [CMD_AW-1:0] a11;
  logic [BLK_W-1:0] wblk;
  logic drop_prog, is_reset;

  assign a11 = wr_addr[CMD_AW-1:0];
  assign wblk = wr_addr[ADDR_W-1 -: BLK_W];
  assign drop_prog = prot_mask[wblk] || ((home_q == M_SUSP) && blk_q[wblk]);
  assign is_reset = (wr_data == D_RESET);
  assign win_wr = (mode_q == M_WIN) && wr_stb;

  always_comb begin
    wr_onehot = '0;
    wr_onehot[wblk] = 1'b1;
  end

  always_comb begin
    mode_n = mode_q;
    home_n = home_q;
    step_n = step_q;
    started_n = started_q;
    blk_n = blk_q;
    paddr_n = paddr_q;
    pdata_n = pdata_q;
    pulse_n = '0;
    case (mode_q)
      M_PROG, M_CHIP: begin
        if (eng_done) begin
          mode_n = eng_err ? M_ERR : home_q;
          step_n = C_IDLE;
        end
      end
      M_BERASE: begin
        if (eng_done) begin
          mode_n = eng_err ? M_ERR : M_READ;
          home_n = M_READ;
          blk_n = '0;
          started_n = 1'b0;
        end else if (wr_stb && wr_data == D_SUSP) begin
          pulse_n[3] = 1'b1;
          mode_n = M_SUSP;
          home_n = M_SUSP;
        end else if (wr_stb && is_reset) begin
          pulse_n[5] = 1'b1;
          mode_n = M_READ;
          home_n = M_READ;
          blk_n = '0;
          started_n = 1'b0;
        end
        step_n = C_IDLE;
      end
      M_WIN: begin
        if (wr_stb) begin
          if (wr_data == D_BLOCK) begin
            blk_n = blk_q | wr_onehot;
          end else if (wr_data == D_SUSP) begin
            mode_n = M_SUSP;
            home_n = M_SUSP;
          end else begin
            mode_n = M_READ;
            home_n = M_READ;
            blk_n = '0;
          end
        end else if (win_expire) begin
          pulse_n[2] = 1'b1;
          mode_n = M_BERASE;
          started_n = 1'b1;
        end
        step_n = C_IDLE;
      end
      M_ERR: begin
        if (wr_stb && is_reset) mode_n = home_q;
        step_n = C_IDLE;
      end
      M_FAST: begin
        if (wr_stb) begin
          step_n = C_IDLE;
          case (step_q)
            C_FPDATA: begin
              if (!drop_prog) begin
                pulse_n[0] = 1'b1;
                paddr_n = wr_addr;
                pdata_n = wr_data;
                mode_n = M_PROG;
              end
            end
            C_FEXIT: begin
              if (wr_data == D_FEXIT) begin
                mode_n = M_READ;
                home_n = M_READ;
              end
            end
            default: begin
              if (wr_data == D_PROG) step_n = C_FPDATA;
              else if (wr_data == D_IDENT) step_n = C_FEXIT;
            end
          endcase
        end
      end
      default: begin  // read, identify, suspended
        if (wr_stb) begin
          step_n = C_IDLE;
          mode_n = home_q;  // a break in the sequence lands here
          if (step_q == C_PDATA) begin
            if (!drop_prog) begin
              pulse_n[0] = 1'b1;
              paddr_n = wr_addr;
              pdata_n = wr_data;
              mode_n = M_PROG;
            end
          end else if (is_reset) begin
            mode_n = home_q;
          end else begin
            case (step_q)
              C_IDLE: begin
                if (cmd_hit(a11, wr_data, ADR_KEY1, D_KEY1)) begin
                  step_n = C_K1;
                  mode_n = mode_q;
                end else if (mode_q == M_SUSP && wr_data == D_BLOCK) begin
                  if (started_q) pulse_n[4] = 1'b1;
                  else pulse_n[2] = 1'b1;
                  mode_n = M_BERASE;
                  home_n = M_READ;
                  started_n = 1'b1;
                end
              end
              C_K1: begin
                if (cmd_hit(a11, wr_data, ADR_KEY2, D_KEY2)) begin
                  step_n = C_K2;
                  mode_n = mode_q;
                end
              end
              C_K2: begin
                if (cmd_hit(a11, wr_data, ADR_KEY1, D_IDENT)) begin
                  mode_n = M_IDENT;
                end else if (cmd_hit(a11, wr_data, ADR_KEY1, D_PROG)) begin
                  step_n = C_PDATA;
                  mode_n = mode_q;
                end else if (cmd_hit(a11, wr_data, ADR_KEY1, D_FAST) && home_q == M_READ) begin
                  mode_n = M_FAST;
                  home_n = M_FAST;
                end else if (cmd_hit(a11, wr_data, ADR_KEY1, D_ERASE) && home_q == M_READ) begin
                  step_n = C_E1;
                  mode_n = mode_q;
                end
              end
              C_E1: begin
                if (cmd_hit(a11, wr_data, ADR_KEY1, D_KEY1)) begin
                  step_n = C_E2;
                  mode_n = mode_q;
                end
              end
              C_E2: begin
                if (cmd_hit(a11, wr_data, ADR_KEY2, D_KEY2)) begin
                  step_n = C_E3;
                  mode_n = mode_q;
                end
              end
              C_E3: begin
                if (cmd_hit(a11, wr_data, ADR_KEY1, D_CHIP)) begin
                  pulse_n[1] = 1'b1;
                  mode_n = M_CHIP;
                  home_n = M_READ;
                end else if (wr_data == D_BLOCK) begin
                  blk_n = wr_onehot;
                  started_n = 1'b0;
                  mode_n = M_WIN;
                  home_n = M_READ;
                end
              end
              default: ;
            endcase
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_READ;
      home_q <= M_READ;
      step_q <= C_IDLE;
      started_q <= 1'b0;
      blk_q <= '0;
      paddr_q <= '0;
      pdata_q <= '0;
      pulse_q <= '0;
    end else begin
      mode_q <= mode_n;
      home_q <= home_n;
      step_q <= step_n;
      started_q <= started_n;
      blk_q <= blk_n;
      paddr_q <= paddr_n;
      pdata_q <= pdata_n;
      pulse_q <= pulse_n;
    end
  end

  assign mode = mode_q;
  assign start_prog = pulse_q[0];
  assign start_chip = pulse_q[1];
  assign start_blk = pulse_q[2];
  assign susp_req = pulse_q[3];
  assign resume_req = pulse_q[4];
  assign abort_req = pulse_q[5];
  assign prog_addr = paddr_q;
  assign prog_data = pdata_q;
  assign erase_blks = blk_q;
endmodule

// File: rtl/fcd_rdsel.sv
module fcd_rdsel import fcd_pkg::*; #(
  parameter int BLK_W = 3,
  parameter logic [7:0] MFR_ID = 8'h20,
  parameter logic [7:0] DEV_ID = 8'hE3,
  localparam int NBLK = 1 << BLK_W
) (
  input  mode_t            mode,
  input  logic [1:0]       rd_sel,
  input  logic [BLK_W-1:0] rd_blk,
  input  logic [NBLK-1:0]  prot_mask,
  input  logic [NBLK-1:0]  erase_blks,
  output src_t             rd_src,
  output logic [7:0]       rd_id
);
  always_comb begin
    rd_src = SRC_STATUS;
    rd_id = 8'h00;
    case (mode)
      M_READ, M_FAST: rd_src = SRC_ARRAY;
      M_IDENT: begin
        rd_src = SRC_IDENT;
        rd_id = ident_byte(rd_sel, prot_mask[rd_blk], MFR_ID, DEV_ID);
      end
      M_SUSP: rd_src = erase_blks[rd_blk] ? SRC_STATUS : SRC_ARRAY;
      default: rd_src = SRC_STATUS;
    endcase
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder import fcd_pkg::*; #(
  parameter int ADDR_W = 19,
  parameter int BLK_W = 3,
  parameter int WIN_CYC = 64,
  parameter logic [7:0] MFR_ID = 8'h20,
  parameter logic [7:0] DEV_ID = 8'hE3,
  localparam int NBLK = 1 << BLK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [NBLK-1:0]   prot_mask,
  input  logic              eng_done,
  input  logic              eng_err,
  output logic [3:0]        mode,
  output logic [1:0]        rd_src,
  output logic [7:0]        rd_id,
  output logic              start_prog,
  output logic              start_chip,
  output logic              start_blk,
  output logic              susp_req,
  output logic              resume_req,
  output logic              abort_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_data,
  output logic [NBLK-1:0]   erase_blks
);
  mode_t mode_w;
  src_t src_w;
  logic win_wr, win_expire;

  fcd_seq #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .prot_mask(prot_mask), .eng_done(eng_done), .eng_err(eng_err),
    .win_expire(win_expire), .mode(mode_w), .win_wr(win_wr),
    .start_prog(start_prog), .start_chip(start_chip), .start_blk(start_blk),
    .susp_req(susp_req), .resume_req(resume_req), .abort_req(abort_req),
    .prog_addr(prog_addr), .prog_data(prog_data), .erase_blks(erase_blks)
  );

  fcd_win_timer #(.WIN_CYC(WIN_CYC)) u_win (
    .clk(clk), .rst_n(rst_n), .run(mode_w == M_WIN), .win_wr(win_wr),
    .expire(win_expire)
  );

  fcd_rdsel #(.BLK_W(BLK_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_rd (
    .mode(mode_w), .rd_sel(rd_addr[1:0]), .rd_blk(rd_addr[ADDR_W-1 -: BLK_W]),
    .prot_mask(prot_mask), .erase_blks(erase_blks), .rd_src(src_w), .rd_id(rd_id)
  );

  assign mode = mode_w;
  assign rd_src = src_w;
endmodule

// File: rtl/fcd_chk.sv
module fcd_chk #(
  parameter int ADDR_W = 19,
  parameter int BLK_W = 3,
  localparam int NBLK = 1 << BLK_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_stb,
  input logic [7:0]        wr_data,
  input logic              eng_done,
  input logic [NBLK-1:0]   prot_mask,
  input logic [3:0]        mode,
  input logic [1:0]        rd_src,
  input logic              start_prog,
  input logic              start_chip,
  input logic              start_blk,
  input logic              susp_req,
  input logic              resume_req,
  input logic              abort_req,
  input logic [ADDR_W-1:0] prog_addr,
  input logic              win_expire
);
  logic [NBLK-1:0] prog_onehot;
  always_comb begin
    prog_onehot = '0;
    prog_onehot[prog_addr[ADDR_W-1 -: BLK_W]] = 1'b1;
  end

  // R4
  prog_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_prog |-> mode == 4'd5);
  // R5
  prog_unprot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_prog |-> ($past(prot_mask) & prog_onehot) == '0);
  // R3
  ident_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 4'd1 |-> rd_src == 2'd1);
  // R9
  chip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'd6 && !eng_done) |=> mode == 4'd6);
  // R10
  win_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_expire |=> (start_blk && mode == 4'd7));
  // R11
  susp_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    susp_req |-> mode == 4'd3);
  // R1
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_prog, start_chip, start_blk, susp_req, resume_req, abort_req}));
  // R14
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'd8 && !(wr_stb && wr_data == 8'hF0)) |=> mode == 4'd8);
endmodule

bind flash_cmd_decoder fcd_chk #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data), .eng_done(eng_done),
  .prot_mask(prot_mask), .mode(mode), .rd_src(rd_src), .start_prog(start_prog),
  .start_chip(start_chip), .start_blk(start_blk), .susp_req(susp_req),
  .resume_req(resume_req), .abort_req(abort_req), .prog_addr(prog_addr),
  .win_expire(win_expire)
);

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_stb = 1'b0;
  logic [18:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, prot_mask = '0;
  logic eng_done = 1'b0, eng_err = 1'b0;
  logic [3:0] mode;
  logic [1:0] rd_src;
  logic [7:0] rd_id, prog_data, erase_blks;
  logic start_prog, start_chip, start_blk, susp_req, resume_req, abort_req;
  logic [18:0] prog_addr;
  int checks = 0, errors = 0;

  flash_cmd_decoder #(.WIN_CYC(WIN)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .prot_mask(prot_mask), .eng_done(eng_done), .eng_err(eng_err),
    .mode(mode), .rd_src(rd_src), .rd_id(rd_id), .start_prog(start_prog),
    .start_chip(start_chip), .start_blk(start_blk), .susp_req(susp_req),
    .resume_req(resume_req), .abort_req(abort_req), .prog_addr(prog_addr),
    .prog_data(prog_data), .erase_blks(erase_blks)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [18:0] a, logic [7:0] d);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic unlock();
    wr(19'h00555, 8'hAA);
    wr(19'h002AA, 8'h55);
  endtask

  task automatic finish_op(logic err);
    @(negedge clk);
    eng_done = 1'b1; eng_err = err;
    @(negedge clk);
    eng_done = 1'b0; eng_err = 1'b0;
  endtask

  task automatic rd(logic [18:0] a);
    rd_addr = a;
    #1;
  endtask

  task automatic t_reset();
    chk("R1 mode", 32'(mode), 0);
    chk("R1 src", 32'(rd_src), 0);
    chk("R1 pulses", 32'({start_prog, start_chip, start_blk, susp_req, resume_req, abort_req}), 0);
  endtask

  task automatic t_ident();
    prot_mask = 8'b0000_0100;
    unlock(); wr(19'h00555, 8'h90);
    chk("R2 ident mode", 32'(mode), 1);
    rd(19'h00000); chk("R3 src", 32'(rd_src), 1); chk("R3 mfr", 32'(rd_id), 32'h20);
    rd(19'h00001); chk("R3 dev", 32'(rd_id), 32'hE3);
    rd(19'h20002); chk("R3 prot blk2", 32'(rd_id), 1);
    rd(19'h30002); chk("R3 unprot blk3", 32'(rd_id), 0);
    rd(19'h00003); chk("R3 sel11", 32'(rd_id), 0);
    wr(19'h12345, 8'hF0);
    chk("R7 reset from ident", 32'(mode), 0);
    prot_mask = '0;
  endtask

  task automatic t_upper_bits();
    wr(19'h7D555, 8'hAA); wr(19'h3AAAA, 8'h55); wr(19'h55555, 8'h90);
    chk("R2 upper bits ignored", 32'(mode), 1);
    wr(19'h0, 8'hF0);
  endtask

  task automatic t_wrong();
    wr(19'h00555, 8'hAA); wr(19'h00555, 8'h55);
    wr(19'h002AA, 8'h55); wr(19'h00555, 8'h90);
    chk("R6 broken prefix", 32'(mode), 0);
    unlock(); wr(19'h00555, 8'h90);
    wr(19'h00123, 8'h77);
    chk("R6 stray write leaves ident", 32'(mode), 0);
    unlock(); wr(19'h002AA, 8'hF0);
    unlock(); wr(19'h00555, 8'h90);
    chk("R7 reset mid-sequence then ident", 32'(mode), 1);
    wr(19'h0, 8'hF0);
  endtask

  task automatic t_program();
    unlock(); wr(19'h00555, 8'hA0); wr(19'h12345, 8'h5A);
    chk("R4 start", 32'(start_prog), 1);
    chk("R4 addr", 32'(prog_addr), 32'h12345);
    chk("R4 data", 32'(prog_data), 32'h5A);
    chk("R4 mode", 32'(mode), 5);
    chk("R4 src", 32'(rd_src), 2);
    @(negedge clk);
    chk("R4 single pulse", 32'(start_prog), 0);
    wr(19'h0, 8'hF0); wr(19'h0, 8'hB0);
    chk("R4 writes ignored", 32'(mode), 5);
    finish_op(1'b0);
    chk("R4 back to read", 32'(mode), 0);
  endtask

  task automatic t_protected();
    prot_mask = 8'b0000_0100;
    unlock(); wr(19'h00555, 8'hA0); wr(19'h20010, 8'h00);
    chk("R5 no start", 32'(start_prog), 0);
    chk("R5 read mode", 32'(mode), 0);
    prot_mask = '0;
  endtask

  task automatic t_fast();
    unlock(); wr(19'h00555, 8'h20);
    chk("R8 fast mode", 32'(mode), 2);
    chk("R8 array reads", 32'(rd_src), 0);
    wr(19'h0, 8'h55); wr(19'h0, 8'hF0);
    chk("R8 other writes ignored", 32'(mode), 2);
    wr(19'h0, 8'hA0); wr(19'h00100, 8'h33);
    chk("R8 two-write program", 32'(start_prog), 1);
    chk("R8 prog data", 32'(prog_data), 32'h33);
    finish_op(1'b0);
    chk("R8 back to fast", 32'(mode), 2);
    wr(19'h0, 8'h90); wr(19'h0, 8'h00);
    chk("R8 exit", 32'(mode), 0);
  endtask

  task automatic t_chip();
    unlock(); wr(19'h00555, 8'h80); unlock(); wr(19'h00555, 8'h10);
    chk("R9 start", 32'(start_chip), 1);
    chk("R9 mode", 32'(mode), 6);
    wr(19'h0, 8'hB0);
    chk("R9 no suspend", 32'(susp_req), 0);
    wr(19'h0, 8'hF0);
    chk("R9 no abort", 32'(abort_req), 0);
    chk("R9 still erasing", 32'(mode), 6);
    finish_op(1'b0);
    chk("R9 done", 32'(mode), 0);
  endtask

  task automatic t_window_suspend();
    unlock(); wr(19'h00555, 8'h80); unlock(); wr(19'h30000, 8'h30);
    chk("R10 window", 32'(mode), 4);
    chk("R10 list", 32'(erase_blks), 32'h08);
    repeat (5) @(negedge clk);
    wr(19'h50000, 8'h30);
    chk("R10 list grows", 32'(erase_blks), 32'h28);
    repeat (WIN - 1) @(negedge clk);
    chk("R10 not yet", 32'(start_blk), 0);
    @(negedge clk);
    chk("R10 start", 32'(start_blk), 1);
    chk("R10 erasing", 32'(mode), 7);
    wr(19'h0, 8'hB0);
    chk("R11 suspend req", 32'(susp_req), 1);
    chk("R11 suspended", 32'(mode), 3);
    rd(19'h30000); chk("R11 listed block status", 32'(rd_src), 2);
    rd(19'h00000); chk("R11 other block array", 32'(rd_src), 0);
    wr(19'h0, 8'h30);
    chk("R11 resume req", 32'(resume_req), 1);
    chk("R11 erasing again", 32'(mode), 7);
    wr(19'h0, 8'hF0);
    chk("R11 abort req", 32'(abort_req), 1);
    chk("R11 read", 32'(mode), 0);
    chk("R11 list cleared", 32'(erase_blks), 0);
  endtask

  task automatic t_early_suspend();
    unlock(); wr(19'h00555, 8'h80); unlock(); wr(19'h10000, 8'h30);
    wr(19'h0, 8'hB0);
    chk("R12 suspended", 32'(mode), 3);
    chk("R12 no suspend req", 32'(susp_req), 0);
    unlock(); wr(19'h00555, 8'hA0); wr(19'h10004, 8'h00);
    chk("R13 listed block dropped", 32'(start_prog), 0);
    chk("R13 still suspended", 32'(mode), 3);
    unlock(); wr(19'h00555, 8'hA0); wr(19'h60000, 8'h12);
    chk("R13 other block programs", 32'(start_prog), 1);
    finish_op(1'b0);
    chk("R13 back to suspended", 32'(mode), 3);
    wr(19'h0, 8'h30);
    chk("R12 start not resume", 32'(start_blk), 1);
    chk("R12 resume low", 32'(resume_req), 0);
    finish_op(1'b0);
    chk("R12 done", 32'(mode), 0);
  endtask

  task automatic t_error();
    unlock(); wr(19'h00555, 8'hA0); wr(19'h00010, 8'h01);
    finish_op(1'b1);
    chk("R14 error mode", 32'(mode), 8);
    chk("R14 status", 32'(rd_src), 2);
    unlock(); wr(19'h00555, 8'h90);
    chk("R14 command ignored", 32'(mode), 8);
    wr(19'h0, 8'hF0);
    chk("R14 cleared", 32'(mode), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ident();
    t_upper_bits();
    t_wrong();
    t_program();
    t_protected();
    t_fast();
    t_chip();
    t_window_suspend();
    t_early_suspend();
    t_error();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule